// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This block is the receive half of a network DMA. It follows a list of four-word descriptors in system memory. Software prepares each descriptor and hands it over by setting its ownership bit. The engine copies words popped from a receive FIFO into the buffers those descriptors point to. A frame may fill one buffer, two buffers of the same descriptor, or several descriptors in a row. When a buffer or frame is finished, the engine writes a status word back into the descriptor and clears ownership, so that software can reclaim it.

When the engine meets a descriptor that software still holds, it parks in a suspended state. It stays there until software pulses a poll-demand input, and then it re-reads the same descriptor. If a frame is still arriving and the following descriptor is unavailable, there are two outcomes. With flushing enabled, the engine marks the current descriptor as errored, discards the rest of the frame and suspends. With flushing disabled, it closes the descriptor as a middle segment and waits, so the frame can resume later. The descriptors can be linked in two ways: as a packed ring that wraps back to the list base, or as a chain that follows an explicit pointer. An optional 64-bit capture time can be written over the pointer words of the final descriptor.

All memory traffic goes through one word-wide request/acknowledge master port. This covers descriptor reads, descriptor write-backs and buffer writes.

Top module: `rxd_dma_engine`

## Requirements
- R1: After reset, and while `run` is low, the engine issues no memory request, does not accept FIFO data, and keeps `suspended` low.
- R2: Raising `run` makes the engine load `list_base` and read word 0 of that descriptor. If bit 31 of word 0 (ownership) is 0, the engine raises `suspended` and accepts no FIFO data.
- R3: For an owned descriptor, the engine reads words 1 to 3 and then writes the accepted FIFO words one after another. They go to the byte address held in word 2, rising by 4 per word. Word 1 bits [11:0] give the size of buffer 1 in words.
- R4: When the word carrying the end-of-frame flag has been written, the engine writes word 0 of the current descriptor with these values: bit 31 = 0, bit 30 (last segment) = 1, bit 28 (error) = 0, and bits [11:0] = the number of words stored in this descriptor.
- R5: If `ts_en` is high when a frame completes, the engine also writes `ts_in[31:0]` into word 2 and `ts_in[63:32]` into word 3. `ts_in` is sampled when the end-of-frame word is accepted. Descriptors closed as middle segments keep words 2 and 3 unchanged.
- R6: Suppose a buffer fills before the frame ends and the next descriptor is owned (bit 31 = 1). The engine then writes word 0 of the current descriptor with bit 31 = 0, bit 30 = 0 and the word count. It then continues the frame in the next descriptor's buffer.
- R7: In ring mode (`ring_mode` = 1), if word 1 bits [23:12] are non-zero, data goes to a second buffer at the byte address in word 3 once buffer 1 is full. That second buffer holds that many words, and word 3 is left unchanged.
- R8: In ring mode, the next descriptor follows the current one at +16 bytes. If word 1 bit 31 (end of ring) is set, the next descriptor is at `list_base` instead.
- R9: In chain mode (`ring_mode` = 0), the next descriptor is at the byte address held in word 3, and the second buffer is not used.
- R10: Suppose a buffer fills mid-frame, the next descriptor is not owned, and `flush_en` = 1. The engine then writes word 0 with bit 28 = 1, bit 31 = 0, bit 30 = 0 and the count. It rewrites word 1 with bit 30 set. It then drops FIFO words up to and including the end-of-frame word, and suspends at the next descriptor.
- R11: In the same case with `flush_en` = 0, the engine closes word 0 as a middle segment, leaves word 1 unchanged, and suspends without consuming more data. After a poll finds the descriptor owned, the rest of the frame goes into its buffer.
- R12: A `poll` pulse while suspended re-reads the same descriptor. Lowering `run` while suspended, or while waiting for FIFO data, stops the engine. A later rise of `run` restarts it from `list_base`.
- R13: Once `mem_req` is raised, it stays high with stable address, write flag and write data until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run/start control |
| poll | input | 1 | Poll-demand pulse, resumes a suspended engine |
| ring_mode | input | 1 | 1 = packed ring with optional second buffer, 0 = chained list |
| flush_en | input | 1 | Discard the frame when the next descriptor is unavailable mid-frame |
| ts_en | input | 1 | Write the capture time into the final descriptor |
| list_base | input | AW | Byte address of the first descriptor |
| ts_in | input | 64 | Free-running capture time |
| fifo_valid | input | 1 | FIFO word available |
| fifo_data | input | 32 | FIFO word |
| fifo_eof | input | 1 | FIFO word ends the frame |
| fifo_ready | output | 1 | FIFO word accepted when valid and ready |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes in this cycle |
| suspended | output | 1 | Engine waits on a descriptor held by software |

## Verification
The assertions assume a well-behaved memory slave that raises `mem_ack` only while `mem_req` is high and returns read data in that same cycle. They also assume that every owned descriptor gives buffer 1 a size of at least one word. The bench's memory model acknowledges every request one cycle after it is raised and never acknowledges an idle port. Every descriptor the bench prepares names a non-zero buffer-1 size. Descriptor words are changed only while the engine is suspended or stopped, so the engine never reads a word in the middle of an update.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [3:0] {
    ST_STOP, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_XFER, ST_WRD,
    ST_NXT, ST_WB0, ST_WB1, ST_WB2, ST_WB3, ST_DROP, ST_SUSP
  } rxd_state_e;

  typedef enum logic [1:0] {
    CK_LAST, CK_MID, CK_ERR
  } rxd_close_e;

  localparam int DW        = 32;
  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 30;
  localparam int ERR_BIT   = 28;
  localparam int EOR_BIT   = 31;
  localparam int FLAST_BIT = 30;

endpackage

// File: rtl/rxd_next_addr.sv
module rxd_next_addr #(
  parameter int AW          = 32,
  parameter int DESC_STRIDE = 16
) (
  input  logic          ring_mode,
  input  logic          end_of_ring,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] chain_ptr,
  output logic [AW-1:0] next_addr
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

  always_comb begin
    if (!ring_mode)
      next_addr = chain_ptr;
    else if (end_of_ring)
      next_addr = base_addr;
    else
      next_addr = cur_addr + STRIDE;
  end
endmodule

// File: rtl/rxd_mem_mux.sv
module rxd_mem_mux
  import rxd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  rxd_state_e       state,
  input  rxd_close_e       close_kind,
  input  logic [AW-1:0]    cur_addr,
  input  logic [AW-1:0]    next_addr,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [DW-1:0]    data_q,
  input  logic [DW-1:0]    word1_q,
  input  logic [CNT_W-1:0] count_q,
  input  logic [63:0]      ts_q,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata
);
  logic [DW-1:0] status_word;

  always_comb begin
    status_word              = '0;
    status_word[LAST_BIT]    = (close_kind == CK_LAST);
    status_word[ERR_BIT]     = (close_kind == CK_ERR);
    status_word[CNT_W-1:0]   = count_q;
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = cur_addr;
    mem_wdata = '0;
    unique case (state)
      ST_RD0:  mem_addr = cur_addr;
      ST_RD1:  mem_addr = cur_addr + AW'(4);
      ST_RD2:  mem_addr = cur_addr + AW'(8);
      ST_RD3:  mem_addr = cur_addr + AW'(12);
      ST_NXT:  mem_addr = next_addr;
      ST_WRD:  begin mem_we = 1'b1; mem_addr = wr_ptr; mem_wdata = data_q; end
      ST_WB0:  begin mem_we = 1'b1; mem_wdata = status_word; end
      ST_WB1:  begin
        mem_we    = 1'b1;
        mem_addr  = cur_addr + AW'(4);
        mem_wdata = word1_q | (DW'(1) << FLAST_BIT);
      end
      ST_WB2:  begin mem_we = 1'b1; mem_addr = cur_addr + AW'(8);  mem_wdata = ts_q[31:0];  end
      ST_WB3:  begin mem_we = 1'b1; mem_addr = cur_addr + AW'(12); mem_wdata = ts_q[63:32]; end
      default: mem_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxd_dma_engine.sv
module rxd_dma_engine
  import rxd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CNT_W       = 12,
  parameter int DESC_STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          poll,
  input  logic          ring_mode,
  input  logic          flush_en,
  input  logic          ts_en,
  input  logic [AW-1:0] list_base,
  input  logic [63:0]   ts_in,
  input  logic          fifo_valid,
  input  logic [31:0]   fifo_data,
  input  logic          fifo_eof,
  output logic          fifo_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          suspended
);
  localparam int LIM_W = CNT_W + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  rxd_state_e       state_q, state_d;
  rxd_close_e       close_q, close_d;
  logic [AW-1:0]    cur_q, cur_d, wr_ptr_q, wr_ptr_d, nxt_addr;
  logic [DW-1:0]    w1_q, w1_d, w2_q, w2_d, w3_q, w3_d, data_q, data_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [63:0]      ts_q, ts_d;
  logic             eof_q, eof_d, in_b2_q, in_b2_d, nown_q, nown_d;
  logic [LIM_W-1:0] size1, size2, limit, cnt_inc;

  assign size1   = {1'b0, w1_q[CNT_W-1:0]};
  assign size2   = {1'b0, w1_q[2*CNT_W-1:CNT_W]};
  assign limit   = in_b2_q ? (size1 + size2) : size1;
  assign cnt_inc = {1'b0, cnt_q} + LIM_W'(1);

  rxd_next_addr #(.AW(AW), .DESC_STRIDE(DESC_STRIDE)) u_next (
    .ring_mode   (ring_mode),
    .end_of_ring (w1_q[EOR_BIT]),
    .cur_addr    (cur_q),
    .base_addr   (list_base),
    .chain_ptr   (w3_q[AW-1:0]),
    .next_addr   (nxt_addr)
  );

  rxd_mem_mux #(.AW(AW), .CNT_W(CNT_W)) u_mux (
    .state      (state_q),
    .close_kind (close_q),
    .cur_addr   (cur_q),
    .next_addr  (nxt_addr),
    .wr_ptr     (wr_ptr_q),
    .data_q     (data_q),
    .word1_q    (w1_q),
    .count_q    (cnt_q),
    .ts_q       (ts_q),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  assign fifo_ready = (state_q == ST_XFER) || (state_q == ST_DROP);
  assign suspended  = (state_q == ST_SUSP);

  always_comb begin
    state_d = state_q; close_d = close_q; cur_d = cur_q; wr_ptr_d = wr_ptr_q;
    w1_d = w1_q; w2_d = w2_q; w3_d = w3_q; data_d = data_q; cnt_d = cnt_q;
    ts_d = ts_q; eof_d = eof_q; in_b2_d = in_b2_q; nown_d = nown_q;
    unique case (state_q)
      ST_STOP: if (run) begin cur_d = list_base; state_d = ST_RD0; end
      ST_RD0:  if (mem_ack) state_d = mem_rdata[OWN_BIT] ? ST_RD1 : ST_SUSP;
      ST_RD1:  if (mem_ack) begin w1_d = mem_rdata; state_d = ST_RD2; end
      ST_RD2:  if (mem_ack) begin w2_d = mem_rdata; state_d = ST_RD3; end
      ST_RD3:  if (mem_ack) begin
        w3_d = mem_rdata; wr_ptr_d = w2_q[AW-1:0];
        cnt_d = '0; in_b2_d = 1'b0; state_d = ST_XFER;
      end
      ST_XFER: begin
        if (fifo_valid) begin
          data_d = fifo_data; eof_d = fifo_eof;
          if (fifo_eof) ts_d = ts_in;
          state_d = ST_WRD;
        end else if (!run) begin
          state_d = ST_STOP;
        end
      end
      ST_WRD: if (mem_ack) begin
        wr_ptr_d = wr_ptr_q + AW'(4);
        cnt_d    = cnt_inc[CNT_W-1:0];
        if (eof_q) begin
          close_d = CK_LAST; state_d = ST_WB0;
        end else if (cnt_inc == limit) begin
          if (ring_mode && !in_b2_q && (size2 != '0)) begin
            in_b2_d = 1'b1; wr_ptr_d = w3_q[AW-1:0]; state_d = ST_XFER;
          end else begin
            state_d = ST_NXT;
          end
        end else begin
          state_d = ST_XFER;
        end
      end
      ST_NXT: if (mem_ack) begin
        nown_d  = mem_rdata[OWN_BIT];
        close_d = (!mem_rdata[OWN_BIT] && flush_en) ? CK_ERR : CK_MID;
        state_d = ST_WB0;
      end
      ST_WB0: if (mem_ack) begin
        unique case (close_q)
          CK_LAST: if (ts_en) state_d = ST_WB2;
                   else begin cur_d = nxt_addr; state_d = ST_RD0; end
          CK_MID:  begin cur_d = nxt_addr; state_d = nown_q ? ST_RD1 : ST_SUSP; end
          default: state_d = ST_WB1;
        endcase
      end
      ST_WB1: if (mem_ack) begin cur_d = nxt_addr; state_d = ST_DROP; end
      ST_WB2: if (mem_ack) state_d = ST_WB3;
      ST_WB3: if (mem_ack) begin cur_d = nxt_addr; state_d = ST_RD0; end
      ST_DROP: begin
        if (fifo_valid && fifo_eof) state_d = ST_SUSP;
        else if (!fifo_valid && !run) state_d = ST_STOP;
      end
      ST_SUSP: begin
        if (!run)      state_d = ST_STOP;
        else if (poll) state_d = ST_RD0;
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_STOP; close_q <= CK_LAST; cur_q <= '0; wr_ptr_q <= '0;
      w1_q <= '0; w2_q <= '0; w3_q <= '0; data_q <= '0; cnt_q <= '0;
      ts_q <= '0; eof_q <= 1'b0; in_b2_q <= 1'b0; nown_q <= 1'b0;
    end else begin
      state_q <= state_d; close_q <= close_d; cur_q <= cur_d; wr_ptr_q <= wr_ptr_d;
      w1_q <= w1_d; w2_q <= w2_d; w3_q <= w3_d; data_q <= data_d; cnt_q <= cnt_d;
      ts_q <= ts_d; eof_q <= eof_d; in_b2_q <= in_b2_d; nown_q <= nown_d;
    end
  end

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2
  own_clear_susp_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_RD0 && mem_ack && !mem_rdata[OWN_BIT]) |=> suspended);

  // R4
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_WB0 && mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  // R1
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    suspended |-> (!mem_req && !fifo_ready));

  // R12
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_STOP && !run) |=> (state_q == ST_STOP && !mem_req));

  // R3
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_XFER && size1 != '0) |-> ({1'b0, cnt_q} < limit));
endmodule

// File: tb/tb_rxd_dma_engine.sv
module tb_rxd_dma_engine;
  localparam int AW = 32;
  localparam logic [63:0] TSV = 64'h1122_3344_A5A6_A7A8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, poll = 0, ring_mode = 1, flush_en = 0, ts_en = 0;
  logic [AW-1:0] list_base = 32'h100;
  logic [63:0] ts_in = TSV;
  logic fifo_valid = 0, fifo_eof = 0;
  logic [31:0] fifo_data = '0;
  logic fifo_ready, mem_req, mem_we, mem_ack, suspended;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:511];
  logic bw_en = 0;
  logic [AW-1:0] bw_addr = '0;
  logic [31:0] bw_data = '0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  rxd_dma_engine dut (
    .clk(clk), .rst_n(rst_n), .run(run), .poll(poll), .ring_mode(ring_mode),
    .flush_en(flush_en), .ts_en(ts_en), .list_base(list_base), .ts_in(ts_in),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
    .fifo_ready(fifo_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .suspended(suspended)
  );

  // memory slave: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[10:2]];
      end else begin
        mem_ack <= 1'b0;
      end
      if (mem_req && mem_ack && mem_we) mem[mem_addr[10:2]] <= mem_wdata;
    end
    if (bw_en) mem[bw_addr[10:2]] <= bw_data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic chk_mem(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    chk(mem[a[10:2]] === exp, tag, mem[a[10:2]], exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 0;
  endtask

  task automatic desc(input logic [AW-1:0] a, input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3);
    wr(a, w0); wr(a + 4, w1); wr(a + 8, w2); wr(a + 12, w3);
  endtask

  task automatic push(input logic [31:0] d, input bit eof);
    @(negedge clk);
    fifo_valid = 1; fifo_data = d; fifo_eof = eof;
    while (!fifo_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fifo_valid = 0; fifo_eof = 0;
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic wait_susp(input string tag);
    int i;
    i = 0;
    @(negedge clk);
    while (!suspended && i < 3000) begin @(negedge clk); i++; end
    chk(suspended === 1'b1, tag, {31'b0, suspended}, 32'h1);
  endtask

  task automatic t_reset();
    repeat (6) @(negedge clk);
    chk(mem_req === 1'b0,    "R1 no request while stopped", {31'b0, mem_req}, 0);
    chk(fifo_ready === 1'b0, "R1 no FIFO accept while stopped", {31'b0, fifo_ready}, 0);
    chk(suspended === 1'b0,  "R1 not suspended after reset", {31'b0, suspended}, 0);
  endtask

  task automatic t_single();
    desc(32'h100, 32'h8000_0000, 32'd8, 32'h200, 32'h0);
    @(negedge clk); run = 1;
    push(32'hA000_0000, 0); push(32'hA000_0001, 0); push(32'hA000_0002, 1);
    wait_susp("R2 suspends on unowned next descriptor");
    chk_mem(32'h200, 32'hA000_0000, "R3 buffer word 0");
    chk_mem(32'h208, 32'hA000_0002, "R3 buffer word 2");
    chk_mem(32'h100, 32'h4000_0003, "R4 final status word");
    chk(fifo_ready === 1'b0, "R2 no data accepted while suspended", {31'b0, fifo_ready}, 0);
  endtask

  task automatic t_span();
    desc(32'h110, 32'h8000_0000, 32'd2, 32'h300, 32'h0);
    desc(32'h120, 32'h8000_0000, 32'd4, 32'h340, 32'h0);
    ts_en = 1;
    do_poll();
    for (int k = 0; k < 5; k++) push(32'hB000_0000 + k, k == 4);
    wait_susp("R12 poll resumes and re-suspends");
    chk_mem(32'h110, 32'h0000_0002, "R6 middle segment status");
    chk_mem(32'h304, 32'hB000_0001, "R6 first buffer tail");
    chk_mem(32'h340, 32'hB000_0002, "R6 continued in next buffer");
    chk_mem(32'h348, 32'hB000_0004, "R6 last word placement");
    chk_mem(32'h120, 32'h4000_0003, "R4 final status after span");
    chk_mem(32'h128, TSV[31:0],  "R5 timestamp low in word 2");
    chk_mem(32'h12C, TSV[63:32], "R5 timestamp high in word 3");
    chk_mem(32'h118, 32'h300, "R5 middle segment keeps word 2");
    ts_en = 0;
  endtask

  task automatic t_buf2();
    desc(32'h130, 32'h8000_0000, (32'd2 << 12) | 32'd1, 32'h380, 32'h390);
    do_poll();
    push(32'hC000_0000, 0); push(32'hC000_0001, 0); push(32'hC000_0002, 1);
    wait_susp("R7 suspends after two-buffer frame");
    chk_mem(32'h380, 32'hC000_0000, "R7 buffer 1 word");
    chk_mem(32'h390, 32'hC000_0001, "R7 buffer 2 first word");
    chk_mem(32'h394, 32'hC000_0002, "R7 buffer 2 second word");
    chk_mem(32'h130, 32'h4000_0003, "R7 count spans both buffers");
    chk_mem(32'h13C, 32'h390, "R7 word 3 unchanged without timestamp");
    chk_mem(32'h128, TSV[31:0], "R5 no timestamp when disabled elsewhere");
  endtask

  task automatic t_flush();
    flush_en = 1;
    desc(32'h140, 32'h8000_0000, 32'd2, 32'h3C0, 32'h0);
    do_poll();
    for (int k = 0; k < 4; k++) push(32'hD000_0000 + k, k == 3);
    wait_susp("R10 suspends after discard");
    chk_mem(32'h140, 32'h1000_0002, "R10 error status word");
    chk_mem(32'h144, 32'h4000_0002, "R10 last flag in word 1");
    chk_mem(32'h3C8, 32'h0, "R10 remainder discarded");
    flush_en = 0;
  endtask

  task automatic t_noflush();
    desc(32'h150, 32'h8000_0000, 32'd2, 32'h400, 32'h0);
    do_poll();
    push(32'hE000_0000, 0); push(32'hE000_0001, 0);
    wait_susp("R11 suspends mid-frame");
    chk_mem(32'h150, 32'h0000_0002, "R11 middle segment close");
    chk_mem(32'h154, 32'h0000_0002, "R11 word 1 untouched");
    repeat (3) @(negedge clk);
    chk(fifo_ready === 1'b0, "R11 no data taken while waiting", {31'b0, fifo_ready}, 0);
    desc(32'h160, 32'h8000_0000, 32'h8000_0004, 32'h440, 32'h0);
    do_poll();
    push(32'hE000_0002, 1);
    wait_susp("R11 frame resumed and closed");
    chk_mem(32'h440, 32'hE000_0002, "R11 rest of frame in new buffer");
    chk_mem(32'h160, 32'h4000_0001, "R11 resumed descriptor status");
  endtask

  task automatic t_wrap();
    desc(32'h100, 32'h8000_0000, 32'd4, 32'h500, 32'h0);
    do_poll();
    push(32'hF000_0000, 1);
    wait_susp("R8 suspends after wrapped frame");
    chk_mem(32'h500, 32'hF000_0000, "R8 end of ring wraps to base");
    chk_mem(32'h100, 32'h4000_0001, "R8 wrapped descriptor status");
  endtask

  task automatic t_chain();
    @(negedge clk); run = 0;
    repeat (3) @(negedge clk);
    chk(suspended === 1'b0, "R12 run low stops engine", {31'b0, suspended}, 0);
    chk(mem_req === 1'b0, "R12 stopped engine idle", {31'b0, mem_req}, 0);
    ring_mode = 0; list_base = 32'h180;
    desc(32'h180, 32'h8000_0000, (32'd3 << 12) | 32'd4, 32'h480, 32'h1A0);
    desc(32'h1A0, 32'h8000_0000, 32'd4, 32'h4C0, 32'h1C0);
    @(negedge clk); run = 1;
    push(32'h9000_0000, 0); push(32'h9000_0001, 1); push(32'h9000_0002, 1);
    wait_susp("R9 suspends at chained end");
    chk_mem(32'h484, 32'h9000_0001, "R12 restart from new list base");
    chk_mem(32'h180, 32'h4000_0002, "R9 first chained status");
    chk_mem(32'h4C0, 32'h9000_0002, "R9 next via word 3 pointer");
    chk_mem(32'h1A0, 32'h4000_0001, "R9 second chained status");
  endtask

  initial begin
    for (int k = 0; k < 512; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_span();
    t_buf2();
    t_flush();
    t_noflush();
    t_wrap();
    t_chain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule